// File: doc/BRIEF.md
# Upstream Read Completion Slot Buffer

This block handles reads that masters on a parallel bus aim at the far side of a bridge. A read that matches nothing already stored is latched. The block then tries to reserve one completion slot for it. The outbound read is issued only once a slot is held. The block breaks the outbound read into sub-requests that fit packet limits. Returned data is written into the reserved slot at the offset that its address gives, so sub-request completions may arrive in any order.

Two return styles are supported. In retry style (`split_mode` low), a master comes back with the same requester ID and the address where it left off. When the next word is present, the block connects and streams words until one of three things happens:
- the transfer ends, which frees the slot;
- the slot runs dry, which makes the block disconnect and keep the slot;
- the master stops, which discards the rest of the prefetched data.

In push style (`split_mode` high), the block waits until a slot holds all of its data. It then returns that slot whole. When several slots are ready, a round-robin choice decides which goes first.

Top module: `rdcpl_slot_buf`

## Requirements
- R1: A request that matches no live slot takes the lowest-numbered free slot and gets response code 1 (retry, queued). Outbound sub-requests carry that slot as their tag and are issued only after the slot is held. If no slot is free, the response is code 0 and no outbound request is issued.
- R2: Each outbound sub-request has a non-zero length of at most `max_rd_bytes` and does not cross a 4096-byte address boundary. Each takes the largest size those limits and the bytes remaining allow. The sub-requests for a slot are issued in ascending address order and together cover exactly the requested range.
- R3: Completion words for a slot may arrive in any order. Each word is stored at the offset equal to its address minus the slot's start address.
- R4: A request matches a slot only when its requester ID equals the slot's ID and its address equals the slot's start address plus the bytes already consumed. A request with another ID is handled as a new read.
- R5: In retry style, a matching request whose next word is present gets response code 2 (connect). From the following cycle, the block outputs one word per cycle, starting at the consumed offset, with the slot's tag and requester ID.
- R6: If the next word is missing while connected, the block pulses `dout_disc` for one cycle without `dout_valid` and keeps the slot. A later matching request resumes from the consumed offset.
- R7: The word that brings the consumed count to the slot length is flagged with `dout_last`, and the slot is freed.
- R8: `mst_stop` in the cycle after a connect ends the transfer without output. The unread data is discarded. No further sub-requests are issued for that slot, and the slot is freed once every sub-request already issued has been completed.
- R9: In push style, a slot is streamed only after all of its bytes have arrived, and no request gets code 2.
- R10: In push style, among the slots that are fully received, the next one streamed is the first in ascending circular order after the most recently streamed slot. The search starts at slot 0 after reset. Each streamed slot ends with `dout_last` and is freed.
- R11: After reset, `rsp_valid`, `out_valid`, `dout_valid` and `dout_disc` are low.
- R12: A matching request whose next word has not yet arrived gets code 1. It produces no output and no new outbound request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_mode | input | 1 | 1 = push style, 0 = retry style |
| max_rd_bytes | input | 13 | Largest outbound read size in bytes (multiple of 4) |
| req_valid | input | 1 | Master read request or retry |
| req_id | input | IDW | Requester ID |
| req_addr | input | AW | Dword-aligned read address |
| req_len | input | log2(SLOT_BYTES)+1 | Byte count for a new read (multiple of 4, at most SLOT_BYTES) |
| mst_stop | input | 1 | Master ends the current transfer |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 0 no slot, 1 retry queued, 2 connect |
| out_valid | output | 1 | Outbound sub-request valid |
| out_ready | input | 1 | Outbound sub-request accepted |
| out_tag | output | log2(NSLOT) | Slot the sub-request fills |
| out_addr | output | AW | Sub-request start address |
| out_len | output | log2(SLOT_BYTES)+1 | Sub-request length in bytes |
| cpl_valid | input | 1 | Completion word valid |
| cpl_tag | input | log2(NSLOT) | Slot of the completion |
| cpl_addr | input | AW | Address of the completion word |
| cpl_data | input | 32 | Completion word |
| dout_valid | output | 1 | Returned data word valid |
| dout_data | output | 32 | Returned data word |
| dout_last | output | 1 | Final word of the slot |
| dout_disc | output | 1 | Disconnect, slot ran dry |
| dout_tag | output | log2(NSLOT) | Slot being returned |
| dout_id | output | IDW | Requester ID of the returned data |

## Verification
The bench builds the block with four slots of 64 bytes and 4-bit requester IDs. With these values, every slot can be filled with a handful of requests, so the no-free-slot answer and the wait for a dropped slot to drain become easy to reach. Small read limits of 16 and 12 bytes force reads to split into several sub-requests, including a sub-request cut short at a 4096-byte boundary. Four slots are also enough to set up a round-robin choice in which the winner is not the lowest-numbered ready slot.

// File: rtl/rdcpl_slot_buf.sv
module rdcpl_slot_buf #(
  parameter int NSLOT      = 8,
  parameter int SLOT_BYTES = 512,
  parameter int IDW        = 8,
  parameter int AW         = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          split_mode,
  input  logic [12:0]                   max_rd_bytes,
  input  logic                          req_valid,
  input  logic [IDW-1:0]                req_id,
  input  logic [AW-1:0]                 req_addr,
  input  logic [$clog2(SLOT_BYTES):0]   req_len,
  input  logic                          mst_stop,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_code,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [$clog2(NSLOT)-1:0]      out_tag,
  output logic [AW-1:0]                 out_addr,
  output logic [$clog2(SLOT_BYTES):0]   out_len,
  input  logic                          cpl_valid,
  input  logic [$clog2(NSLOT)-1:0]      cpl_tag,
  input  logic [AW-1:0]                 cpl_addr,
  input  logic [31:0]                   cpl_data,
  output logic                          dout_valid,
  output logic [31:0]                   dout_data,
  output logic                          dout_last,
  output logic                          dout_disc,
  output logic [$clog2(NSLOT)-1:0]      dout_tag,
  output logic [IDW-1:0]                dout_id
);
  localparam int SW   = SLOT_BYTES / 4;
  localparam int OFFW = $clog2(SW);
  localparam int SLW  = $clog2(NSLOT);
  localparam int LENW = $clog2(SLOT_BYTES) + 1;

  logic [NSLOT-1:0]    busy, drop, rdy;
  logic [IDW-1:0]      s_id   [NSLOT];
  logic [AW-1:0]       s_addr [NSLOT];
  logic [LENW-1:0]     s_len  [NSLOT];
  logic [LENW-1:0]     s_iss  [NSLOT];
  logic [LENW-1:0]     s_rcv  [NSLOT];
  logic [LENW-1:0]     s_con  [NSLOT];
  logic [NSLOT*SW-1:0] wv;
  logic [31:0]         mem [NSLOT*SW];

  logic           act;
  logic [SLW-1:0] act_slot, rr;

  logic           fr_ok, m_ok, is_ok, g_ok;
  logic [SLW-1:0] fr_idx, m_idx, is_idx, g_idx;

  always_comb begin
    fr_ok = 1'b0; fr_idx = '0;
    m_ok = 1'b0;  m_idx = '0;
    is_ok = 1'b0; is_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      rdy[i] = split_mode && busy[i] && !drop[i] && (s_rcv[i] == s_len[i]);
      if (!busy[i]) begin
        fr_ok = 1'b1; fr_idx = SLW'(i);
      end
      if (busy[i] && !drop[i] && s_id[i] == req_id &&
          (s_addr[i] + AW'(s_con[i])) == req_addr) begin
        m_ok = 1'b1; m_idx = SLW'(i);
      end
      if (busy[i] && s_iss[i] < s_len[i]) begin
        is_ok = 1'b1; is_idx = SLW'(i);
      end
    end
  end

  logic [SLW-1:0] rr_j;
  always_comb begin
    g_ok = 1'b0; g_idx = '0; rr_j = '0;
    for (int k = NSLOT; k >= 1; k--) begin
      rr_j = rr + SLW'(k);
      if (rdy[rr_j]) begin
        g_ok = 1'b1; g_idx = rr_j;
      end
    end
  end

  logic [AW-1:0] cur_addr;
  logic [12:0]   rem13, to4k, chunk;
  always_comb begin
    cur_addr = s_addr[is_idx] + AW'(s_iss[is_idx]);
    rem13    = 13'(s_len[is_idx] - s_iss[is_idx]);
    to4k     = 13'd4096 - {1'b0, cur_addr[11:0]};
    chunk    = rem13;
    if (max_rd_bytes < chunk) chunk = max_rd_bytes;
    if (to4k < chunk) chunk = to4k;
  end

  assign out_valid = is_ok;
  assign out_tag   = is_idx;
  assign out_addr  = cur_addr;
  assign out_len   = LENW'(chunk);

  wire                  issue_go = is_ok && out_ready;
  wire [SLW+OFFW-1:0]   m_wi  = {m_idx, s_con[m_idx][OFFW+1:2]};
  wire                  m_has = wv[m_wi];
  wire [SLW+OFFW-1:0]   a_wi  = {act_slot, s_con[act_slot][OFFW+1:2]};
  wire                  a_has = wv[a_wi];
  wire                  a_end = (s_con[act_slot] + LENW'(4)) == s_len[act_slot];
  wire [LENW-1:0]       a_issn = s_iss[act_slot] +
                          ((issue_go && is_idx == act_slot) ? LENW'(chunk) : '0);
  wire [OFFW-1:0]       c_off = OFFW'((cpl_addr - s_addr[cpl_tag]) >> 2);
  wire [SLW+OFFW-1:0]   c_wi  = {cpl_tag, c_off};

  always_ff @(posedge clk)
    if (cpl_valid) mem[c_wi] <= cpl_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; drop <= '0; wv <= '0;
      act <= 1'b0; act_slot <= '0; rr <= SLW'(NSLOT - 1);
      rsp_valid <= 1'b0; rsp_code <= 2'd0;
      dout_valid <= 1'b0; dout_last <= 1'b0; dout_disc <= 1'b0;
      dout_data <= '0; dout_tag <= '0; dout_id <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        s_id[i] <= '0; s_addr[i] <= '0; s_len[i] <= '0;
        s_iss[i] <= '0; s_rcv[i] <= '0; s_con[i] <= '0;
      end
    end else begin
      rsp_valid  <= 1'b0;
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
      dout_disc  <= 1'b0;

      if (issue_go)
        s_iss[is_idx] <= s_iss[is_idx] + LENW'(chunk);

      if (cpl_valid) begin
        s_rcv[cpl_tag] <= s_rcv[cpl_tag] + LENW'(4);
        wv[c_wi]       <= 1'b1;
      end

      for (int i = 0; i < NSLOT; i++)
        if (busy[i] && drop[i] && s_rcv[i] == s_len[i]) begin
          busy[i] <= 1'b0;
          drop[i] <= 1'b0;
        end

      if (req_valid) begin
        rsp_valid <= 1'b1;
        if (m_ok) begin
          if (!split_mode && !act && m_has) begin
            rsp_code <= 2'd2;
            act      <= 1'b1;
            act_slot <= m_idx;
          end else begin
            rsp_code <= 2'd1;
          end
        end else if (fr_ok) begin
          rsp_code       <= 2'd1;
          busy[fr_idx]   <= 1'b1;
          drop[fr_idx]   <= 1'b0;
          s_id[fr_idx]   <= req_id;
          s_addr[fr_idx] <= req_addr;
          s_len[fr_idx]  <= req_len;
          s_iss[fr_idx]  <= '0;
          s_rcv[fr_idx]  <= '0;
          s_con[fr_idx]  <= '0;
          for (int w = 0; w < SW; w++)
            wv[{fr_idx, OFFW'(w)}] <= 1'b0;
        end else begin
          rsp_code <= 2'd0;
        end
      end

      if (act) begin
        dout_tag <= act_slot;
        dout_id  <= s_id[act_slot];
        if (!split_mode && mst_stop) begin
          act             <= 1'b0;
          drop[act_slot]  <= 1'b1;
          s_len[act_slot] <= a_issn;
        end else if (split_mode || a_has) begin
          dout_valid      <= 1'b1;
          dout_data       <= mem[a_wi];
          s_con[act_slot] <= s_con[act_slot] + LENW'(4);
          if (a_end) begin
            dout_last      <= 1'b1;
            busy[act_slot] <= 1'b0;
            act            <= 1'b0;
          end
        end else begin
          dout_disc <= 1'b1;
          dout_data <= '0;
          act       <= 1'b0;
        end
      end else if (g_ok) begin
        act      <= 1'b1;
        act_slot <= g_idx;
        rr       <= g_idx;
      end
    end
  end
endmodule

// File: rtl/rdcpl_slot_buf_chk.sv
module rdcpl_slot_buf_chk #(
  parameter int SLOT_BYTES = 512,
  parameter int AW         = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        split_mode,
  input logic [12:0]                 max_rd_bytes,
  input logic                        mst_stop,
  input logic                        rsp_valid,
  input logic [1:0]                  rsp_code,
  input logic                        out_valid,
  input logic [AW-1:0]               out_addr,
  input logic [$clog2(SLOT_BYTES):0] out_len,
  input logic                        dout_valid,
  input logic                        dout_last,
  input logic                        dout_disc
);
  // R2
  out_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != 0) && (13'(out_len) <= max_rd_bytes));

  // R2
  out_4k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_addr[11:0]} + 13'(out_len)) <= 13'd4096);

  // R5
  conn_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd2 && !mst_stop) |=> dout_valid);

  // R6
  disc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_disc |-> !dout_valid);

  // R7
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> dout_valid);

  // R9
  push_noconn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(split_mode)) |-> rsp_code != 2'd2);
endmodule

bind rdcpl_slot_buf rdcpl_slot_buf_chk #(.SLOT_BYTES(SLOT_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .max_rd_bytes(max_rd_bytes),
  .mst_stop(mst_stop), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .out_valid(out_valid), .out_addr(out_addr), .out_len(out_len),
  .dout_valid(dout_valid), .dout_last(dout_last), .dout_disc(dout_disc)
);

// File: tb/rdcpl_slot_buf_bench.sv
module rdcpl_slot_buf_bench;
  localparam int NSLOT = 4, SLOT_BYTES = 64, IDW = 4, AW = 32;
  localparam int LENW = 7, SLW = 2;

  logic clk = 1'b0, rst_n = 1'b0, split_mode = 1'b0;
  logic [12:0] max_rd_bytes = 13'd16;
  logic req_valid = 1'b0, mst_stop = 1'b0, out_ready = 1'b1, cpl_valid = 1'b0;
  logic [IDW-1:0] req_id = '0;
  logic [AW-1:0] req_addr = '0, cpl_addr = '0;
  logic [LENW-1:0] req_len = '0;
  logic [SLW-1:0] cpl_tag = '0;
  logic [31:0] cpl_data = '0;
  logic rsp_valid, out_valid, dout_valid, dout_last, dout_disc;
  logic [1:0] rsp_code;
  logic [SLW-1:0] out_tag, dout_tag;
  logic [AW-1:0] out_addr;
  logic [LENW-1:0] out_len;
  logic [31:0] dout_data;
  logic [IDW-1:0] dout_id;

  rdcpl_slot_buf #(.NSLOT(NSLOT), .SLOT_BYTES(SLOT_BYTES), .IDW(IDW), .AW(AW)) u_rdcpl_slot_buf (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .max_rd_bytes(max_rd_bytes),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr), .req_len(req_len),
    .mst_stop(mst_stop), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_addr(out_addr), .out_len(out_len), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_addr(cpl_addr), .cpl_data(cpl_data), .dout_valid(dout_valid),
    .dout_data(dout_data), .dout_last(dout_last), .dout_disc(dout_disc),
    .dout_tag(dout_tag), .dout_id(dout_id));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, beats = 0;
  string phase = "R11";
  logic [37:0] sbq[$];
  logic [AW-1:0] oq_a[$];
  logic [LENW-1:0] oq_l[$];
  logic [SLW-1:0] oq_t[$];

  function automatic logic [31:0] fdat(input logic [AW-1:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      oq_a.push_back(out_addr); oq_l.push_back(out_len); oq_t.push_back(out_tag);
    end

  always @(negedge clk)
    if (rst_n && (dout_valid || dout_disc)) begin
      logic [37:0] got, exp;
      got = {dout_disc, dout_last, dout_id, dout_data};
      beats++; n_chk++;
      if (sbq.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected beat actual=%h expected=none", phase, got);
      end else begin
        exp = sbq.pop_front();
        if (got !== exp) begin
          n_fail++;
          $display("FAIL %s beat actual=%h expected=%h", phase, got, exp);
        end
      end
    end

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_req(input int id, input logic [AW-1:0] a, input int len,
                        input logic [1:0] exp_code, input bit stop, input string r);
    @(negedge clk);
    req_valid = 1'b1; req_id = IDW'(id); req_addr = a; req_len = LENW'(len);
    @(negedge clk);
    req_valid = 1'b0; mst_stop = stop;
    check(rsp_valid && rsp_code == exp_code, r, {rsp_valid, rsp_code}, {1'b1, exp_code});
    if (stop) begin
      @(negedge clk);
      mst_stop = 1'b0;
    end
  endtask

  task automatic push_stream(input int id, input logic [AW-1:0] a, input int n,
                             input bit last, input bit disc);
    for (int k = 0; k < n; k++)
      sbq.push_back({1'b0, last && (k == n - 1), IDW'(id), fdat(a + AW'(4 * k))});
    if (disc) sbq.push_back({1'b1, 1'b0, IDW'(id), 32'h0});
  endtask

  task automatic send_cpl(input logic [SLW-1:0] t, input logic [AW-1:0] base,
                          input int first, input int n, input bit rev);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = rev ? first + n - 1 - k : first + k;
      @(negedge clk);
      cpl_valid = 1'b1; cpl_tag = t;
      cpl_addr = base + AW'(4 * idx); cpl_data = fdat(cpl_addr);
    end
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic check_out(input logic [AW-1:0] a, input int len, input string r,
                           output logic [SLW-1:0] tag);
    logic [AW-1:0] ea;
    int rem, c;
    bit first;
    repeat (8) @(negedge clk);
    ea = a; rem = len; first = 1'b1; tag = '0;
    while (rem > 0) begin
      c = rem;
      if (int'(max_rd_bytes) < c) c = int'(max_rd_bytes);
      if (4096 - int'(ea[11:0]) < c) c = 4096 - int'(ea[11:0]);
      if (oq_a.size() == 0) begin
        check(1'b0, r, 64'hdead, {ea, 16'(c)});
        rem = 0;
      end else begin
        logic [AW-1:0] ga; logic [LENW-1:0] gl; logic [SLW-1:0] gt;
        ga = oq_a.pop_front(); gl = oq_l.pop_front(); gt = oq_t.pop_front();
        if (first) tag = gt;
        check(ga == ea && int'(gl) == c && gt == tag, r, {ga, 8'(gl), 8'(gt)}, {ea, 8'(c), 8'(tag)});
        first = 1'b0; ea = ea + AW'(c); rem = rem - c;
      end
    end
    check(oq_a.size() == 0, r, 64'(oq_a.size()), 64'd0);
  endtask

  task automatic drain(input string r);
    for (int k = 0; k < 100 && sbq.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, r, 64'(sbq.size()), 64'd0);
  endtask

  task automatic run();
    logic [SLW-1:0] t1, t2, t3, t4, t5, t6, t7, t8, t9, t10, tx;
    int b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!rsp_valid && !out_valid && !dout_valid && !dout_disc, "R11",
          {rsp_valid, out_valid, dout_valid, dout_disc}, 4'b0);

    // R1 new read reserves a slot, R2 split by max size
    phase = "R1";
    do_req(1, 32'h100, 32, 2'd1, 1'b0, "R1");
    check_out(32'h100, 32, "R2", t1);
    // R12 retry without data
    phase = "R12";
    do_req(1, 32'h100, 32, 2'd1, 1'b0, "R12");
    check_out(32'h100, 0, "R12", tx);
    drain("R12");
    // R3 completions out of order, R5 connect, R7 last
    phase = "R3";
    send_cpl(t1, 32'h100, 4, 4, 1'b1);
    send_cpl(t1, 32'h100, 0, 4, 1'b1);
    push_stream(1, 32'h100, 8, 1'b1, 1'b0);
    do_req(1, 32'h100, 32, 2'd2, 1'b0, "R5");
    drain("R3");

    // R4 match needs the same requester
    phase = "R4";
    do_req(2, 32'h200, 16, 2'd1, 1'b0, "R4");
    check_out(32'h200, 16, "R4", t2);
    check(t2 == 0, "R7", 64'(t2), 64'd0);
    do_req(3, 32'h200, 16, 2'd1, 1'b0, "R4");
    check_out(32'h200, 16, "R4", t3);
    check(t3 != t2, "R4", 64'(t3), 64'(t2));

    // R6 disconnect when dry, resume at consumed offset
    phase = "R6";
    send_cpl(t2, 32'h200, 0, 2, 1'b0);
    push_stream(2, 32'h200, 2, 1'b0, 1'b1);
    do_req(2, 32'h200, 16, 2'd2, 1'b0, "R6");
    drain("R6");
    send_cpl(t2, 32'h200, 2, 2, 1'b0);
    push_stream(2, 32'h208, 2, 1'b1, 1'b0);
    do_req(2, 32'h208, 16, 2'd2, 1'b0, "R6");
    drain("R6");

    // R1 fill all slots, then no slot
    phase = "R1";
    do_req(4, 32'h300, 16, 2'd1, 1'b0, "R1");
    check_out(32'h300, 16, "R1", t4);
    do_req(5, 32'h400, 16, 2'd1, 1'b0, "R1");
    check_out(32'h400, 16, "R1", t5);
    do_req(6, 32'h500, 16, 2'd1, 1'b0, "R1");
    check_out(32'h500, 16, "R1", t6);
    do_req(7, 32'h600, 16, 2'd0, 1'b0, "R1");
    check_out(32'h600, 0, "R1", tx);

    // R8 stop discards, slot waits for outstanding data
    phase = "R8";
    send_cpl(t4, 32'h300, 0, 1, 1'b0);
    do_req(4, 32'h300, 16, 2'd2, 1'b1, "R8");
    drain("R8");
    do_req(7, 32'h600, 16, 2'd0, 1'b0, "R8");
    send_cpl(t4, 32'h300, 1, 3, 1'b0);
    repeat (3) @(negedge clk);
    do_req(7, 32'h600, 16, 2'd1, 1'b0, "R8");
    check_out(32'h600, 16, "R8", t7);
    check(t7 == t4, "R8", 64'(t7), 64'(t4));

    // R10 push style, all four ready, order from slot 0
    phase = "R10";
    send_cpl(t7, 32'h600, 0, 4, 1'b0);
    send_cpl(t3, 32'h200, 0, 4, 1'b0);
    send_cpl(t5, 32'h400, 0, 4, 1'b0);
    send_cpl(t6, 32'h500, 0, 4, 1'b0);
    for (int s = 0; s < NSLOT; s++) begin
      if (t7 == SLW'(s)) push_stream(7, 32'h600, 4, 1'b1, 1'b0);
      if (t3 == SLW'(s)) push_stream(3, 32'h200, 4, 1'b1, 1'b0);
      if (t5 == SLW'(s)) push_stream(5, 32'h400, 4, 1'b1, 1'b0);
      if (t6 == SLW'(s)) push_stream(6, 32'h500, 4, 1'b1, 1'b0);
    end
    @(negedge clk); split_mode = 1'b1;
    drain("R10");
    @(negedge clk); split_mode = 1'b0;

    // R9 push style waits for a full slot
    phase = "R9";
    do_req(8, 32'h700, 16, 2'd1, 1'b0, "R9");
    check_out(32'h700, 16, "R9", t8);
    do_req(9, 32'h800, 16, 2'd1, 1'b0, "R9");
    check_out(32'h800, 16, "R9", t9);
    do_req(10, 32'h900, 16, 2'd1, 1'b0, "R9");
    check_out(32'h900, 16, "R9", t10);
    check(t8 < t9 && t9 < t10, "R1", {8'(t8), 8'(t9), 8'(t10)}, 24'h000102);
    @(negedge clk); split_mode = 1'b1;
    send_cpl(t9, 32'h800, 0, 2, 1'b0);
    b0 = beats;
    repeat (6) @(negedge clk);
    check(beats == b0, "R9", 64'(beats), 64'(b0));
    do_req(9, 32'h800, 16, 2'd1, 1'b0, "R9");
    push_stream(9, 32'h800, 4, 1'b1, 1'b0);
    send_cpl(t9, 32'h800, 2, 2, 1'b0);
    drain("R9");
    @(negedge clk); split_mode = 1'b0;

    // R10 round-robin picks the slot after the last served one
    phase = "R10";
    send_cpl(t8, 32'h700, 0, 4, 1'b0);
    send_cpl(t10, 32'h900, 0, 4, 1'b0);
    push_stream(10, 32'h900, 4, 1'b1, 1'b0);
    push_stream(8, 32'h700, 4, 1'b1, 1'b0);
    @(negedge clk); split_mode = 1'b1;
    drain("R10");
    @(negedge clk); split_mode = 1'b0;

    // R2 boundary and odd maximum size
    phase = "R2";
    do_req(11, 32'hFF8, 32, 2'd1, 1'b0, "R2");
    check_out(32'hFF8, 32, "R2", tx);
    max_rd_bytes = 13'd12;
    do_req(12, 32'h1000, 32, 2'd1, 1'b0, "R2");
    check_out(32'h1000, 32, "R2", tx);
    drain("R2");
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule